// File: doc/BRIEF.md
# Sequential Word Programming Controller

This block is the control core of a serial flash's sequential word programming mode. An SPI front-end deserialises each frame and hands the bytes over one at a time. The block collects them while chip select is low and acts on the frame when chip select rises.

The first frame of a run carries the mode opcode, a three-byte address and two data bytes. Each later frame carries only the opcode and two data bytes. The block keeps the word pointer itself, so the host never resends an address.

Each accepted frame produces a single 16-bit write request on the memory write port. It also starts a programming timer that holds busy for a fixed number of cycles. The block tracks the write-enable latch and the mode flag, and it refuses any start word that lies inside the protected upper region of the array. When the last unprotected word has been written, the mode ends by itself; the pointer never wraps around to the bottom. On request, the block drives a ready/busy level onto the serial output pin whenever chip select is low during the mode.

Top module: `flash_wordseq_ctrl`

## Requirements
- R1: After a synchronous reset, busy, wel, incr_mode, mem_we and so_oe are all 0.
- R2: An entry frame carries 6 bytes: ADh, then a three-byte address (most significant byte first), then data D0 and data D1. It is accepted when wel is 1, incr_mode is 0, busy is 0 and the start word is unprotected. In the cycle after chip select rises, it raises mem_we for exactly one cycle with mem_word = address >> 1 and mem_wdata = {D1, D0}. D0 is the even byte (bits 7:0) and D1 is the odd byte (bits 15:8). The same edge sets incr_mode.
- R3: While incr_mode is 1 and busy is 0, a 3-byte frame ADh, D0, D1 writes {D1, D0} to the word that follows the one written last.
- R4: busy rises in the same cycle as mem_we and stays high for exactly PROG_CYCLES cycles. No write is issued before chip select rises.
- R5: While busy is 1, only the status read (05h) and write disable (04h) frames are accepted. A word frame sent during busy produces no write and leaves the word pointer unchanged.
- R6: While incr_mode is 1, every opcode except ADh, 05h and 04h is ignored. This includes 70h, 80h and 06h.
- R7: A 1-byte frame 04h clears incr_mode and wel at any time. It does not stop a busy period that is already running.
- R8: An entry frame sent while wel is 0 is ignored.
- R9: The protection level prot_level marks the upper part of the array as protected. Level 0 protects nothing. Levels 1, 2, 3 and 4 protect the upper 1/16, 1/8, 1/4 and 1/2 of the array. Levels 5 to 7 protect the whole array. An entry frame whose start word is protected is ignored.
- R10: A write to the highest unprotected word clears incr_mode and wel on the same edge that raises mem_we. The pointer does not wrap, and later word frames are ignored.
- R11: The 1-byte frame 70h (outside the mode) turns the busy pin on, and 80h turns it off. When the pin is on and incr_mode is 1, chip select low makes so_oe 1 one cycle later, with so_bit = 0 while busy and 1 when ready. Chip select high makes so_oe 0 one cycle later.
- R12: A frame whose length does not match its opcode is ignored. Entry needs exactly 6 bytes; a word frame inside the mode and all other commands need exactly the length given above.
- R13: Outside the mode and not busy, the 1-byte frame 06h sets wel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte from the front-end |
| prot_level | input | 3 | Block protection level from the status register |
| mem_we | output | 1 | One-cycle word program request |
| mem_word | output | ADDR_W-1 | Word address of the request |
| mem_wdata | output | 16 | {odd byte, even byte} |
| busy | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable latch |
| incr_mode | output | 1 | Sequential word mode active |
| so_oe | output | 1 | Drive the serial output with so_bit |
| so_bit | output | 1 | Ready (1) / busy (0) level |

## Verification
A wrong word pointer shows up on the very next accepted word frame as a wrong mem_word, and in the final byte image of the memory model. A stale mode flag or latch shows up in the cycle after chip select rises, either as a write that should not occur or as a missing one. The exit condition and the protection decode are checked at the boundary words of every protection level. The busy period is checked to the exact cycle. The pin output is sampled one cycle after each chip select edge.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int FRAME_MAX = 6;

  localparam logic [7:0] OP_SEQ_WORD = 8'hAD;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_WR_OFF   = 8'h04;
  localparam logic [7:0] OP_WR_ON    = 8'h06;
  localparam logic [7:0] OP_PIN_ON   = 8'h70;
  localparam logic [7:0] OP_PIN_OFF  = 8'h80;

  typedef enum logic [2:0] {
    K_NONE,
    K_WR_OFF,
    K_WR_ON,
    K_PIN_ON,
    K_PIN_OFF,
    K_ENTRY,
    K_CONT
  } frame_kind_e;
endpackage

// File: rtl/wseq_frame_capture.sv
module wseq_frame_capture #(
  parameter int FRAME_MAX = 6,
  localparam int LEN_W = $clog2(FRAME_MAX + 2)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_byte,
  output logic                       frame_end,
  output logic [LEN_W-1:0]           frame_len,
  output logic [FRAME_MAX-1:0][7:0]  frame_bytes
);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(FRAME_MAX + 1);

  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b1;
    else     cs_q <= cs_n;
  end

  // frame closes on the cycle chip select is seen high after being low
  assign frame_end = cs_n & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst || cs_n)                           frame_len <= '0;
    else if (rx_valid && frame_len != LEN_SAT) frame_len <= frame_len + 1'b1;
  end

  for (genvar i = 0; i < FRAME_MAX; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                           frame_bytes[i] <= '0;
      else if (!cs_n && rx_valid && frame_len == LEN_W'(i)) frame_bytes[i] <= rx_byte;
    end
  end

  assert_len_cleared_R12: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> frame_len <= LEN_W'(1));
endmodule

// File: rtl/wseq_prot_bound.sv
module wseq_prot_bound #(
  parameter int WORD_AW = 7
) (
  input  logic [2:0]       level,
  output logic [WORD_AW:0] first_prot
);
  localparam logic [WORD_AW:0] WORDS = (WORD_AW + 1)'(1) << WORD_AW;

  always_comb begin
    case (level)
      3'd0:    first_prot = WORDS;
      3'd1:    first_prot = WORDS - (WORDS >> 4);
      3'd2:    first_prot = WORDS - (WORDS >> 3);
      3'd3:    first_prot = WORDS - (WORDS >> 2);
      3'd4:    first_prot = WORDS - (WORDS >> 1);
      default: first_prot = '0;
    endcase
  end

  always_comb begin
    assert_bound_in_range_R9: assert (first_prot <= WORDS);
  end
endmodule

// File: rtl/wseq_busy_timer.sv
module wseq_busy_timer #(
  parameter int PROG_CYCLES = 1400,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= CNT_W'(PROG_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/wseq_busy_pin.sv
module wseq_busy_pin (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic pin_en,
  input  logic mode,
  input  logic busy,
  output logic so_oe,
  output logic so_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      so_oe  <= 1'b0;
      so_bit <= 1'b1;
    end else begin
      so_oe  <= pin_en & mode & ~cs_n;
      so_bit <= ~busy;
    end
  end

  assert_pin_needs_select_R11: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> !$past(cs_n));
endmodule

// File: rtl/flash_wordseq_ctrl.sv
module flash_wordseq_ctrl
  import wseq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int PROG_CYCLES = 1400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [2:0]        prot_level,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_word,
  output logic [15:0]       mem_wdata,
  output logic              busy,
  output logic              wel,
  output logic              incr_mode,
  output logic              so_oe,
  output logic              so_bit
);
  localparam int WORD_AW = ADDR_W - 1;
  localparam int LEN_W   = $clog2(FRAME_MAX + 2);

  logic                      frame_end;
  logic [LEN_W-1:0]          frame_len;
  logic [FRAME_MAX-1:0][7:0] frame_bytes;
  logic [WORD_AW:0]          first_prot;
  logic [WORD_AW-1:0]        next_word;
  logic [WORD_AW-1:0]        start_word;
  logic                      pin_en;
  logic                      ent_ok, cont_ok, ent_last, cont_last, prog_start;
  frame_kind_e               kind;
  logic [7:0]                op;

  wseq_frame_capture #(.FRAME_MAX(FRAME_MAX)) u_cap (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_end(frame_end), .frame_len(frame_len), .frame_bytes(frame_bytes)
  );

  wseq_prot_bound #(.WORD_AW(WORD_AW)) u_bound (
    .level(prot_level), .first_prot(first_prot)
  );

  wseq_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(prog_start), .busy(busy)
  );

  wseq_busy_pin u_pin (
    .clk(clk), .rst(rst), .cs_n(cs_n), .pin_en(pin_en), .mode(incr_mode),
    .busy(busy), .so_oe(so_oe), .so_bit(so_bit)
  );

  assign op         = frame_bytes[0];
  assign start_word = WORD_AW'({frame_bytes[1], frame_bytes[2], frame_bytes[3]} >> 1);

  // classify the finished frame; write disable passes even while busy
  always_comb begin
    kind = K_NONE;
    if (frame_end) begin
      if (op == OP_WR_OFF && frame_len == LEN_W'(1)) begin
        kind = K_WR_OFF;
      end else if (!busy) begin
        if (incr_mode) begin
          if (op == OP_SEQ_WORD && frame_len == LEN_W'(3)) kind = K_CONT;
        end else begin
          case (op)
            OP_WR_ON:    if (frame_len == LEN_W'(1))         kind = K_WR_ON;
            OP_PIN_ON:   if (frame_len == LEN_W'(1))         kind = K_PIN_ON;
            OP_PIN_OFF:  if (frame_len == LEN_W'(1))         kind = K_PIN_OFF;
            OP_SEQ_WORD: if (frame_len == LEN_W'(FRAME_MAX)) kind = K_ENTRY;
            OP_STAT_RD:  kind = K_NONE;
            default:     kind = K_NONE;
          endcase
        end
      end
    end
  end

  assign ent_ok     = wel && ({1'b0, start_word} < first_prot);
  assign cont_ok    = ({1'b0, next_word} < first_prot);
  assign ent_last   = (({1'b0, start_word} + (WORD_AW + 1)'(1)) == first_prot);
  assign cont_last  = (({1'b0, next_word} + (WORD_AW + 1)'(1)) == first_prot);
  assign prog_start = (kind == K_ENTRY && ent_ok) || (kind == K_CONT && cont_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      wel       <= 1'b0;
      incr_mode <= 1'b0;
      pin_en    <= 1'b0;
      next_word <= '0;
      mem_we    <= 1'b0;
      mem_word  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (kind)
        K_WR_OFF: begin
          wel       <= 1'b0;
          incr_mode <= 1'b0;
        end
        K_WR_ON:   wel    <= 1'b1;
        K_PIN_ON:  pin_en <= 1'b1;
        K_PIN_OFF: pin_en <= 1'b0;
        K_ENTRY: begin
          if (ent_ok) begin
            mem_we    <= 1'b1;
            mem_word  <= start_word;
            mem_wdata <= {frame_bytes[5], frame_bytes[4]};
            next_word <= start_word + 1'b1;
            if (ent_last) wel       <= 1'b0;
            else          incr_mode <= 1'b1;
          end
        end
        K_CONT: begin
          if (cont_ok) begin
            mem_we    <= 1'b1;
            mem_word  <= next_word;
            mem_wdata <= {frame_bytes[2], frame_bytes[1]};
            next_word <= next_word + 1'b1;
            if (cont_last) begin
              incr_mode <= 1'b0;
              wel       <= 1'b0;
            end
          end else begin
            // boundary moved under the pointer: leave the mode
            incr_mode <= 1'b0;
            wel       <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assert_write_starts_busy_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_no_write_when_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(busy));

  assert_mode_needs_latch_R8: assert property (@(posedge clk) disable iff (rst)
    incr_mode |-> wel);

  assert_write_below_bound_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ({1'b0, mem_word} < $past(first_prot)));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
endmodule

// File: tb/flash_wordseq_ctrl_tb.sv
module flash_wordseq_ctrl_tb;
  localparam int AW    = 8;
  localparam int PROG  = 12;
  localparam int WORDS = 1 << (AW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic [2:0]    prot_level = '0;
  logic          mem_we;
  logic [AW-2:0] mem_word;
  logic [15:0]   mem_wdata;
  logic          busy, wel, incr_mode, so_oe, so_bit;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mem_img [1 << AW];
  logic [7:0] exp_mem [1 << AW];
  int sweep_words [11] = '{0, 31, 63, 64, 95, 96, 111, 112, 119, 120, 127};

  always #2.5 clk = ~clk;

  flash_wordseq_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .prot_level(prot_level), .mem_we(mem_we), .mem_word(mem_word),
    .mem_wdata(mem_wdata), .busy(busy), .wel(wel), .incr_mode(incr_mode),
    .so_oe(so_oe), .so_bit(so_bit)
  );

  // memory model fed from the write port
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      mem_img[{mem_word, 1'b0}] = mem_wdata[7:0];
      mem_img[{mem_word, 1'b1}] = mem_wdata[15:8];
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [7:0] b0, input logic [7:0] b1 = 8'h00,
                      input logic [7:0] b2 = 8'h00, input logic [7:0] b3 = 8'h00,
                      input logic [7:0] b4 = 8'h00, input logic [7:0] b5 = 8'h00);
    logic [7:0] bb [6];
    bb = '{b0, b1, b2, b3, b4, b5};
    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_byte  = bb[i];
      @(negedge clk);
    end
    rx_valid = 1'b0;
    cs_n     = 1'b1;
    @(negedge clk);
  endtask

  task automatic entry(input logic [7:0] addr, input logic [7:0] lo, input logic [7:0] hi);
    xfer(6, 8'hAD, 8'h00, 8'h00, addr, lo, hi);
  endtask

  task automatic cont(input logic [7:0] lo, input logic [7:0] hi);
    xfer(3, 8'hAD, lo, hi);
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
  endtask

  task automatic expect_word(input int w, input logic [7:0] lo, input logic [7:0] hi);
    exp_mem[2*w]   = lo;
    exp_mem[2*w+1] = hi;
  endtask

  task automatic hold_cs(input int cycles);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int bound_of(input int lvl);
    if (lvl == 0) return WORDS;
    if (lvl >= 5) return 0;
    return WORDS - (WORDS >> (5 - lvl));
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int cnt;
    for (int i = 0; i < (1 << AW); i++) begin
      mem_img[i] = 8'hFF;
      exp_mem[i] = 8'hFF;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "wel", wel, 0);
    chk("R1", "mode", incr_mode, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "so_oe", so_oe, 0);

    // R8 entry without write enable
    entry(8'h20, 8'h11, 8'h22);
    chk("R8", "mem_we", mem_we, 0);
    chk("R8", "mode", incr_mode, 0);

    // R13 write enable
    xfer(1, 8'h06);
    chk("R13", "wel", wel, 1);

    // R12 short entry frame
    xfer(5, 8'hAD, 8'h00, 8'h00, 8'h20, 8'h33);
    chk("R12", "mem_we", mem_we, 0);
    chk("R12", "mode", incr_mode, 0);
    chk("R12", "wel", wel, 1);

    // R2 entry at odd byte address 0x21 -> word 0x10
    entry(8'h21, 8'hA1, 8'hB2);
    chk("R2", "mem_we", mem_we, 1);
    chk("R2", "mem_word", mem_word, 'h10);
    chk("R2", "mem_wdata", mem_wdata, 'hB2A1);
    chk("R2", "mode", incr_mode, 1);
    expect_word('h10, 8'hA1, 8'hB2);
    // R4 busy length
    cnt = 0;
    while (busy) begin
      cnt++;
      @(negedge clk);
    end
    chk("R4", "busy cycles", cnt, PROG);

    // R3 continuation
    cont(8'hC3, 8'hD4);
    chk("R3", "mem_we", mem_we, 1);
    chk("R3", "mem_word", mem_word, 'h11);
    chk("R3", "mem_wdata", mem_wdata, 'hD4C3);
    expect_word('h11, 8'hC3, 8'hD4);
    // R5 word frame during busy is dropped
    cont(8'h55, 8'h66);
    chk("R5", "busy", busy, 1);
    chk("R5", "mem_we", mem_we, 0);
    wait_ready();
    cont(8'h77, 8'h88);
    chk("R5", "pointer", mem_word, 'h12);
    expect_word('h12, 8'h77, 8'h88);
    wait_ready();

    // R6 pin enable ignored inside the mode
    xfer(1, 8'h70);
    hold_cs(3);
    chk("R6", "so_oe", so_oe, 0);
    release_cs();

    // R7 write disable while busy
    cont(8'h99, 8'hAA);
    chk("R3", "mem_word", mem_word, 'h13);
    expect_word('h13, 8'h99, 8'hAA);
    xfer(1, 8'h04);
    chk("R7", "mode", incr_mode, 0);
    chk("R7", "wel", wel, 0);
    chk("R7", "busy", busy, 1);
    wait_ready();
    cont(8'hEE, 8'hEF);
    chk("R7", "mem_we", mem_we, 0);

    // R11 busy pin
    xfer(1, 8'h70);
    xfer(1, 8'h06);
    entry(8'h60, 8'h12, 8'h34);
    expect_word('h30, 8'h12, 8'h34);
    hold_cs(2);
    chk("R11", "so_oe", so_oe, 1);
    chk("R11", "so_bit busy", so_bit, 0);
    wait_ready();
    @(negedge clk);
    @(negedge clk);
    chk("R11", "so_bit ready", so_bit, 1);
    chk("R11", "so_oe", so_oe, 1);
    release_cs();
    chk("R11", "so_oe released", so_oe, 0);
    xfer(1, 8'h80);
    hold_cs(2);
    chk("R6", "so_oe after 80h in mode", so_oe, 1);
    release_cs();
    xfer(1, 8'h04);
    xfer(1, 8'h80);
    xfer(1, 8'h06);
    entry(8'h62, 8'h56, 8'h78);
    expect_word('h31, 8'h56, 8'h78);
    hold_cs(2);
    chk("R11", "so_oe disabled", so_oe, 0);
    release_cs();
    xfer(1, 8'h04);
    wait_ready();

    // R10 auto exit at protected boundary (level 3 -> word 96)
    prot_level = 3'd3;
    xfer(1, 8'h06);
    entry(8'd188, 8'h41, 8'h42);
    chk("R10", "mem_word", mem_word, 94);
    chk("R10", "mode", incr_mode, 1);
    expect_word(94, 8'h41, 8'h42);
    wait_ready();
    cont(8'h43, 8'h44);
    chk("R10", "mem_word", mem_word, 95);
    chk("R10", "mode", incr_mode, 0);
    chk("R10", "wel", wel, 0);
    expect_word(95, 8'h43, 8'h44);
    wait_ready();
    cont(8'h45, 8'h46);
    chk("R10", "mem_we", mem_we, 0);
    // R10 top of array, no wrap
    prot_level = 3'd0;
    xfer(1, 8'h06);
    entry(8'd252, 8'h51, 8'h52);
    expect_word(126, 8'h51, 8'h52);
    wait_ready();
    cont(8'h53, 8'h54);
    chk("R10", "top word", mem_word, 127);
    chk("R10", "mode", incr_mode, 0);
    expect_word(127, 8'h53, 8'h54);
    wait_ready();
    cont(8'h55, 8'h56);
    chk("R10", "no wrap", mem_we, 0);

    // R9 sweep of protection levels and start words
    for (int lvl = 0; lvl < 8; lvl++) begin
      prot_level = 3'(lvl);
      for (int k = 0; k < 11; k++) begin
        int sw;
        int bnd;
        bit acc;
        logic [7:0] lo;
        sw  = sweep_words[k];
        bnd = bound_of(lvl);
        acc = (sw < bnd);
        lo  = 8'(lvl * 16 + k);
        xfer(1, 8'h06);
        entry(8'(sw * 2), lo, ~lo);
        chk("R9", "mem_we", mem_we, acc);
        chk("R9", "mode", incr_mode, acc && (sw + 1 != bnd));
        if (acc) begin
          chk("R9", "mem_word", mem_word, sw);
          expect_word(sw, lo, ~lo);
        end
        xfer(1, 8'h04);
        wait_ready();
      end
    end

    // R2 / R3 final image of the memory model
    @(negedge clk);
    for (int i = 0; i < (1 << AW); i++) begin
      chk("R2", $sformatf("byte %0d", i), mem_img[i], exp_mem[i]);
    end

    summary();
  end
endmodule